// File: doc/BRIEF.md
# SD Host Vendor Register Shim

This block sits between the system register bus and the register port of a standard SD host controller. It adds a small set of vendor-specific registers and rules, and passes every other access through unchanged. It holds a second control register and an ADMA error/status register of its own. It can refuse reads of the buffer data port, and it rewrites the clock-stable flag on every write to the clock control register. When the ADMA engine has halted, the shim issues a one-cycle resume pulse to the engine, but only if software asks for it in the right DMA mode.

Bus accesses are 1, 2 or 4 bytes wide and may start at any byte offset within a 32-bit word. Write data and read data are right-justified to the access size. The `size` encoding is 0 for a byte, 1 for a halfword, and 2 or 3 for a word. A word access always covers the whole word, whatever the low address bits are. Byte lanes that would fall beyond the end of the word are dropped. Writes and forwarded reads reach the downstream port combinationally in the same cycle. Read data is returned one cycle after the read strobe. For a forwarded read, `rdata` in that cycle is taken from `ds_rdata`.

The default word offsets are as follows:
- Buffer data port: 0x020.
- Clock control: 0x02C. Bit 2 is the SD clock enable and bit 3 is the clock-stable flag.
- ADMA error register: 0x054. Bit 8 is interrupt status, bit 9 is continue request and bit 10 is final block.
- Second control register: 0x080. Bit 6 disables buffer-port reads.

The 32-bit ADMA2 mode is code 2 on `host_dma_mode`.

Top module: `sdhc_vendor_shim`

## Requirements
- R1: After reset, the second control register and the ADMA error register read as zero, the stopped flag is clear, and `rvalid` and `adma_resume` are low.
- R2: `rvalid` is high in exactly the cycle after a read strobe. Any access outside the shim's own two registers appears on `ds_*` in the same cycle with the same address and size; for a forwarded read, `rdata` equals `ds_rdata`.
- R3: Writes to the second control register update only the addressed byte lanes, for 1-, 2- and 4-byte accesses at any offset.
- R4: While bit 6 of the second control register is set, a read of the buffer data port word returns zero and raises no `ds_rd_en`. Otherwise the read is forwarded.
- R5: On a forwarded write that covers byte lane 0 of the clock control word, `ds_wdata[3]` equals `wdata[2] AND card_present`. All other data bits, and any write not covering lane 0, pass through unchanged.
- R6: The ADMA error register uses its special write path only for a 4-byte write, a 2-byte write at byte offset 0, or a 1-byte write at byte offset 1. The byte at offset 1 lands in bits 15:8.
- R7: On the special path, bit 10 (final block) keeps its stored value and bit 9 (continue request) is stored as zero. Bit 8 keeps its value unless cleared by R8. All other addressed bits take the written data, and unaddressed lanes are kept.
- R8: On the special path, writing 1 to bit 8 clears it, and writing 0 leaves it unchanged.
- R9: `adma_resume` pulses for one cycle after a special-path write, and the stopped flag clears, only when all three conditions hold: the stopped flag is set, the written bit 9 is 1, and `host_dma_mode` equals 2.
- R10: Any other write to the ADMA error register deposits the addressed bytes as written, with no bit kept and no resume.
- R11: Reads of the two local registers return the addressed byte lanes right-justified and zero-extended. A 4-byte read returns the whole word.
- R12: An `adma_halt` pulse sets the stopped flag. If a halt and a resuming write meet at the same edge, the flag stays set.
- R13: Accesses to the two local registers never raise `ds_wr_en` or `ds_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| wdata | input | 32 | Right-justified write data |
| rdata | output | 32 | Right-justified read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| card_present | input | 1 | Card-inserted bit of the present-state register |
| host_dma_mode | input | 2 | DMA-select field of the host control register |
| adma_halt | input | 1 | Pulse from the ADMA engine when it stops |
| adma_resume | output | 1 | One-cycle pulse to resume the ADMA engine |
| ds_wr_en | output | 1 | Forwarded write strobe |
| ds_rd_en | output | 1 | Forwarded read strobe |
| ds_addr | output | ADDR_W | Forwarded address |
| ds_size | output | 2 | Forwarded size |
| ds_wdata | output | 32 | Forwarded write data, clock-stable bit rewritten |
| ds_rdata | input | 32 | Downstream read data, one cycle after ds_rd_en |

## Verification
The bench first seeds bits 8 to 10 of the ADMA error register through a 2-byte write at offset 1. That write is not a special-path shape, so a design that routes it down the special path would lose those bits, and one that stores bit 9 on the special path would show it in a later read. The resume pulse is driven through every case where one of its three conditions is missing, and a shim that ignores any condition pulses where none is expected. The bench also makes a halt coincide with a resuming write; a design that lets the clear win at that edge would not resume on the next continue request. Further checks cover the clock-stable rewrite for each combination of enable and card presence, and for a write that misses lane 0, and they cover halfword reads that run past the end of the word.

// File: rtl/sdhc_shim_pkg.sv
package sdhc_shim_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam int AERR_IRQ_BIT   = 8;
    localparam int AERR_CONT_BIT  = 9;
    localparam int AERR_FINAL_BIT = 10;
    localparam int CTRL2_RDDIS_BIT = 6;
    localparam int CLK_EN_BIT   = 2;
    localparam int CLK_STBL_BIT = 3;
    localparam logic [1:0] DMA_ADMA2_32 = 2'b10;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl2;
        logic [DATA_W-1:0] aerr;
        logic              stopped;
        logic              resume;
        logic              rvalid;
        logic              rd_local;
        logic [DATA_W-1:0] rd_data;
    } shim_state_t;
endpackage

// File: rtl/sdhc_shim_decode.sv
module sdhc_shim_decode
    import sdhc_shim_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BDATA_OFS = 'h020,
    parameter int CLK_OFS   = 'h02C,
    parameter int AERR_OFS  = 'h054,
    parameter int CTRL2_OFS = 'h080
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] be_mask,
    output logic [DATA_W-1:0] lane_data,
    output logic [1:0]        off,
    output logic              hit_bdata,
    output logic              hit_clk,
    output logic              hit_aerr,
    output logic              hit_ctrl2,
    output logic              aerr_special
);
    localparam logic [ADDR_W-1:0] BDATA_A = ADDR_W'(BDATA_OFS);
    localparam logic [ADDR_W-1:0] CLK_A   = ADDR_W'(CLK_OFS);
    localparam logic [ADDR_W-1:0] AERR_A  = ADDR_W'(AERR_OFS);
    localparam logic [ADDR_W-1:0] CTRL2_A = ADDR_W'(CTRL2_OFS);

    logic is_word;

    always_comb begin
        is_word = size[1];
        off     = is_word ? 2'd0 : addr[1:0];
        unique case (size)
            2'b00:   be = 4'(4'b0001 << off);
            2'b01:   be = 4'(4'b0011 << off);
            default: be = 4'b1111;
        endcase
        lane_data = wdata << {off, 3'b000};

        hit_bdata = addr[ADDR_W-1:2] == BDATA_A[ADDR_W-1:2];
        hit_clk   = addr[ADDR_W-1:2] == CLK_A[ADDR_W-1:2];
        hit_aerr  = addr[ADDR_W-1:2] == AERR_A[ADDR_W-1:2];
        hit_ctrl2 = addr[ADDR_W-1:2] == CTRL2_A[ADDR_W-1:2];

        aerr_special = hit_aerr &&
                       (is_word ||
                        (size == 2'b01 && off == 2'd0) ||
                        (size == 2'b00 && off == 2'd1));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_mask[8*i +: 8] = {8{be[i]}};
    end
endmodule

// File: rtl/sdhc_lane_extract.sv
module sdhc_lane_extract
    import sdhc_shim_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = word >> {off, 3'b000};
        unique case (size)
            2'b00:   data = {24'd0, shifted[7:0]};
            2'b01:   data = {16'd0, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/sdhc_vendor_shim.sv
module sdhc_vendor_shim
    import sdhc_shim_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BDATA_OFS = 'h020,
    parameter int CLK_OFS   = 'h02C,
    parameter int AERR_OFS  = 'h054,
    parameter int CTRL2_OFS = 'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic              card_present,
    input  logic [1:0]        host_dma_mode,
    input  logic              adma_halt,
    output logic              adma_resume,
    output logic              ds_wr_en,
    output logic              ds_rd_en,
    output logic [ADDR_W-1:0] ds_addr,
    output logic [1:0]        ds_size,
    output logic [31:0]       ds_wdata,
    input  logic [31:0]       ds_rdata
);
    localparam logic [DATA_W-1:0] KEEP_BITS =
        (DATA_W'(1) << AERR_FINAL_BIT) | (DATA_W'(1) << AERR_IRQ_BIT);
    localparam logic [DATA_W-1:0] NOSTORE_BITS =
        KEEP_BITS | (DATA_W'(1) << AERR_CONT_BIT);
    localparam logic [DATA_W-1:0] IRQ_MASK = DATA_W'(1) << AERR_IRQ_BIT;

    shim_state_t st_d, st_q;

    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] be_mask, lane_data, wr_val, ext_src, ext_data;
    logic [1:0]        off;
    logic              hit_bdata, hit_clk, hit_aerr, hit_ctrl2, aerr_special;
    logic              local_hit;

    sdhc_shim_decode #(
        .ADDR_W(ADDR_W), .BDATA_OFS(BDATA_OFS), .CLK_OFS(CLK_OFS),
        .AERR_OFS(AERR_OFS), .CTRL2_OFS(CTRL2_OFS)
    ) u_decode (
        .addr(addr), .size(size), .wdata(wdata),
        .be(be), .be_mask(be_mask), .lane_data(lane_data), .off(off),
        .hit_bdata(hit_bdata), .hit_clk(hit_clk), .hit_aerr(hit_aerr),
        .hit_ctrl2(hit_ctrl2), .aerr_special(aerr_special)
    );

    assign ext_src = hit_ctrl2 ? st_q.ctrl2 : st_q.aerr;

    sdhc_lane_extract u_extract (
        .word(ext_src), .off(off), .size(size), .data(ext_data)
    );

    always_comb begin
        st_d          = st_q;
        st_d.resume   = 1'b0;
        st_d.rvalid   = rd_en;
        st_d.rd_local = 1'b0;
        st_d.rd_data  = '0;

        local_hit = hit_ctrl2 || hit_aerr;
        wr_val    = lane_data & be_mask;

        ds_wr_en = 1'b0;
        ds_rd_en = 1'b0;
        ds_addr  = addr;
        ds_size  = size;
        ds_wdata = wdata;

        if (wr_en) begin
            if (hit_ctrl2) begin
                st_d.ctrl2 = (st_q.ctrl2 & ~be_mask) | wr_val;
            end else if (hit_aerr) begin
                if (aerr_special) begin
                    st_d.aerr = ((st_q.aerr & (~be_mask | KEEP_BITS)) |
                                 (wr_val & ~NOSTORE_BITS)) &
                                ~(wr_val & IRQ_MASK);
                    if (st_q.stopped && wr_val[AERR_CONT_BIT] &&
                        host_dma_mode == DMA_ADMA2_32) begin
                        st_d.stopped = 1'b0;
                        st_d.resume  = 1'b1;
                    end
                end else begin
                    st_d.aerr = (st_q.aerr & ~be_mask) | wr_val;
                end
            end else begin
                ds_wr_en = 1'b1;
                if (hit_clk && be[0]) begin
                    ds_wdata[CLK_STBL_BIT] = wdata[CLK_EN_BIT] && card_present;
                end
            end
        end

        if (adma_halt) begin
            st_d.stopped = 1'b1;
        end

        if (rd_en) begin
            if (local_hit) begin
                st_d.rd_local = 1'b1;
                st_d.rd_data  = ext_data;
            end else if (hit_bdata && st_q.ctrl2[CTRL2_RDDIS_BIT]) begin
                st_d.rd_local = 1'b1;
            end else begin
                ds_rd_en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata       = st_q.rd_local ? st_q.rd_data : ds_rdata;
    assign rvalid      = st_q.rvalid;
    assign adma_resume = st_q.resume;
endmodule

// File: rtl/sdhc_shim_checker.sv
module sdhc_shim_checker #(
    parameter int ADDR_W    = 12,
    parameter int BDATA_OFS = 'h020,
    parameter int CLK_OFS   = 'h02C,
    parameter int AERR_OFS  = 'h054,
    parameter int CTRL2_OFS = 'h080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic [31:0]       wdata,
    input logic              card_present,
    input logic [1:0]        host_dma_mode,
    input logic              ds_wr_en,
    input logic              ds_rd_en,
    input logic [31:0]       ds_wdata,
    input logic [31:0]       rdata,
    input logic              rvalid,
    input logic              adma_resume,
    input logic              rd_disable
);
    localparam logic [ADDR_W-1:0] BDATA_A = ADDR_W'(BDATA_OFS);
    localparam logic [ADDR_W-1:0] CLK_A   = ADDR_W'(CLK_OFS);
    localparam logic [ADDR_W-1:0] AERR_A  = ADDR_W'(AERR_OFS);
    localparam logic [ADDR_W-1:0] CTRL2_A = ADDR_W'(CTRL2_OFS);

    logic on_bdata, on_clk, on_local, lane0;
    assign on_bdata = addr[ADDR_W-1:2] == BDATA_A[ADDR_W-1:2];
    assign on_clk   = addr[ADDR_W-1:2] == CLK_A[ADDR_W-1:2];
    assign on_local = (addr[ADDR_W-1:2] == AERR_A[ADDR_W-1:2]) ||
                      (addr[ADDR_W-1:2] == CTRL2_A[ADDR_W-1:2]);
    assign lane0    = size[1] || (addr[1:0] == 2'd0);

    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    a_r2_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    a_r4_gate_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && on_bdata && rd_disable) |-> !ds_rd_en);
    a_r4_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && on_bdata && rd_disable) |=> (rdata == 32'd0));
    a_r5_clk_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_wr_en && on_clk && lane0) |->
            (ds_wdata[3] == (wdata[2] && card_present)));
    a_r9_resume_mode: assert property (@(posedge clk) disable iff (!rst_n)
        adma_resume |-> ($past(wr_en) && $past(host_dma_mode) == 2'b10));
    a_r13_local_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && on_local) |-> (!ds_wr_en && !ds_rd_en));
endmodule

bind sdhc_vendor_shim sdhc_shim_checker #(
    .ADDR_W(ADDR_W), .BDATA_OFS(BDATA_OFS), .CLK_OFS(CLK_OFS),
    .AERR_OFS(AERR_OFS), .CTRL2_OFS(CTRL2_OFS)
) u_shim_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .card_present(card_present),
    .host_dma_mode(host_dma_mode), .ds_wr_en(ds_wr_en), .ds_rd_en(ds_rd_en),
    .ds_wdata(ds_wdata), .rdata(rdata), .rvalid(rvalid),
    .adma_resume(adma_resume), .rd_disable(st_q.ctrl2[6])
);

// File: tb/test_sdhc_vendor_shim.sv
`timescale 1ns/1ps
module test_sdhc_vendor_shim;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_BDATA = 12'h020, A_CLK = 12'h02C,
                              A_AERR  = 12'h054, A_CTRL2 = 12'h080,
                              A_OTHER = 12'h010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, card_present = 0, adma_halt = 0;
    logic [AW-1:0] addr = '0;
    logic [1:0] size = 2'b00, host_dma_mode = 2'b00;
    logic [31:0] wdata = '0, ds_rdata = '0;
    logic [31:0] rdata, ds_wdata;
    logic rvalid, adma_resume, ds_wr_en, ds_rd_en;
    logic [AW-1:0] ds_addr;
    logic [1:0] ds_size;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] ctrl2_m = '0, aerr_m = '0;
    bit stopped_m = 0, exp_resume = 0, exp_rvalid = 0;

    always #2.5 clk = ~clk;

    sdhc_vendor_shim i_sdhc_vendor_shim (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .card_present(card_present), .host_dma_mode(host_dma_mode),
        .adma_halt(adma_halt), .adma_resume(adma_resume),
        .ds_wr_en(ds_wr_en), .ds_rd_en(ds_rd_en), .ds_addr(ds_addr),
        .ds_size(ds_size), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata)
    );

    // downstream register port: answers one cycle after its read strobe
    always @(posedge clk) if (ds_rd_en) ds_rdata <= {20'hD5000, ds_addr};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the registered pulse outputs
    always @(negedge clk) if (rst_n && !done) begin
        chk(rvalid == exp_rvalid, "R2 rvalid", 32'(rvalid), 32'(exp_rvalid));
        chk(adma_resume == exp_resume, "R9 resume", 32'(adma_resume), 32'(exp_resume));
    end

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    function automatic int start_lane(input logic [1:0] s, input logic [AW-1:0] a);
        return (nbytes(s) == 4) ? 0 : int'(a[1:0]);
    endfunction

    function automatic logic [31:0] pick(input logic [31:0] w, input logic [AW-1:0] a,
                                         input logic [1:0] s);
        logic [31:0] r = '0;
        int o = start_lane(s, a);
        for (int i = 0; i < 8 * nbytes(s); i++)
            if (8 * o + i < 32) r[i] = w[8 * o + i];
        return r;
    endfunction

    function automatic logic [31:0] deposit(input logic [31:0] old, input logic [AW-1:0] a,
                                            input logic [1:0] s, input logic [31:0] d);
        logic [31:0] r = old;
        int o = start_lane(s, a);
        for (int b = 0; b < 32; b++)
            if (b / 8 >= o && b / 8 < o + nbytes(s)) r[b] = d[b - 8 * o];
        return r;
    endfunction

    task automatic aerr_write(input logic [AW-1:0] a, input logic [1:0] s,
                              input logic [31:0] d, output logic [31:0] nv,
                              output bit cont);
        int n = nbytes(s);
        int o = start_lane(s, a);
        bit special = (n == 4) || (n == 2 && o == 0) || (n == 1 && o == 1);
        nv = aerr_m;
        cont = 0;
        for (int b = 0; b < 32; b++) begin
            if (b / 8 >= o && b / 8 < o + n) begin
                bit v = d[b - 8 * o];
                if (!special)    nv[b] = v;
                else if (b == 10) nv[b] = aerr_m[b];
                else if (b == 9) begin nv[b] = 1'b0; cont = v; end
                else if (b == 8) begin if (v) nv[b] = 1'b0; end
                else             nv[b] = v;
            end
        end
        cont = cont && special;
    endtask

    // one clock with the currently driven inputs; model steps alongside
    task automatic cycle();
        logic [31:0] n_ctrl2 = ctrl2_m, n_aerr = aerr_m;
        bit cont = 0, res, halt = adma_halt, rdv = rd_en;
        if (wr_en && addr[AW-1:2] == A_CTRL2[AW-1:2])
            n_ctrl2 = deposit(ctrl2_m, addr, size, wdata);
        if (wr_en && addr[AW-1:2] == A_AERR[AW-1:2])
            aerr_write(addr, size, wdata, n_aerr, cont);
        res = cont && stopped_m && host_dma_mode == 2'b10;
        @(posedge clk);
        #1;
        ctrl2_m = n_ctrl2;
        aerr_m = n_aerr;
        stopped_m = (stopped_m && !res) || halt;
        exp_resume = res;
        exp_rvalid = rdv;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] s,
                      input logic [31:0] d, input string tag);
        bit local_reg = (a[AW-1:2] == A_CTRL2[AW-1:2]) || (a[AW-1:2] == A_AERR[AW-1:2]);
        logic [31:0] exp_d = d;
        addr = a; size = s; wdata = d; wr_en = 1;
        if (a[AW-1:2] == A_CLK[AW-1:2] && start_lane(s, a) == 0)
            exp_d[3] = d[2] && card_present;
        #1;
        chk(ds_wr_en == !local_reg, {tag, " ds_wr_en"}, 32'(ds_wr_en), 32'(!local_reg));
        if (!local_reg) begin
            chk(ds_wdata == exp_d, {tag, " ds_wdata"}, ds_wdata, exp_d);
            chk(ds_addr == a && ds_size == s, {tag, " ds_addr"}, 32'(ds_addr), 32'(a));
        end
        cycle();
        wr_en = 0;
        chk(adma_resume == exp_resume, {tag, " resume"}, 32'(adma_resume), 32'(exp_resume));
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, input string tag);
        logic [31:0] exp;
        bit fwd = 1;
        if (a[AW-1:2] == A_CTRL2[AW-1:2]) begin exp = pick(ctrl2_m, a, s); fwd = 0; end
        else if (a[AW-1:2] == A_AERR[AW-1:2]) begin exp = pick(aerr_m, a, s); fwd = 0; end
        else if (a[AW-1:2] == A_BDATA[AW-1:2] && ctrl2_m[6]) begin exp = '0; fwd = 0; end
        else exp = {20'hD5000, a};
        addr = a; size = s; rd_en = 1;
        #1;
        chk(ds_rd_en == fwd, {tag, " ds_rd_en"}, 32'(ds_rd_en), 32'(fwd));
        cycle();
        rd_en = 0;
        chk(rvalid == 1'b1, {tag, " rvalid"}, 32'(rvalid), 32'd1);
        chk(rdata == exp, {tag, " rdata"}, rdata, exp);
    endtask

    task automatic halt_pulse();
        adma_halt = 1;
        cycle();
        adma_halt = 0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rvalid == 0 && adma_resume == 0, "R1 reset outputs",
            32'({rvalid, adma_resume}), 32'd0);
        rst_n = 1;
        @(negedge clk);
        rd(A_CTRL2, 2'b10, "R1 ctrl2 reset");
        rd(A_AERR, 2'b10, "R1 aerr reset");

        // R3 / R11: byte-lane writes and right-justified reads
        wr(A_CTRL2 + 2, 2'b00, 32'h5A, "R3 byte");
        rd(A_CTRL2, 2'b10, "R3 word read");
        wr(A_CTRL2 + 1, 2'b01, 32'h1234, "R3 half off1");
        rd(A_CTRL2 + 2, 2'b00, "R11 byte read");
        rd(A_CTRL2 + 3, 2'b01, "R11 half past end");
        wr(A_CTRL2 + 3, 2'b10, 32'hC0DE_0081, "R3 word ignores offset");
        rd(A_CTRL2 + 1, 2'b10, "R11 word read");

        // R2 / R13: forwarding
        wr(A_OTHER, 2'b10, 32'hFEED_0001, "R2 fwd write");
        rd(A_OTHER + 1, 2'b01, "R2 fwd read");
        rd(A_CTRL2, 2'b00, "R13 local read");

        // R4: buffer port gate (bit 6 of ctrl2 is currently 0 after 0x81? set it)
        wr(A_CTRL2, 2'b00, 32'h00, "R4 clear gate");
        rd(A_BDATA, 2'b10, "R4 ungated");
        wr(A_CTRL2, 2'b00, 32'h40, "R4 set gate");
        rd(A_BDATA, 2'b10, "R4 gated");
        rd(A_BDATA + 2, 2'b00, "R4 gated byte");
        wr(A_CTRL2, 2'b00, 32'h00, "R4 clear gate again");
        rd(A_BDATA, 2'b01, "R4 ungated again");

        // R5: clock-stable rewrite
        card_present = 1;
        wr(A_CLK, 2'b01, 32'h0004, "R5 en+card");
        wr(A_CLK, 2'b10, 32'h0001_0105, "R5 word en+card");
        card_present = 0;
        wr(A_CLK, 2'b01, 32'h000C, "R5 no card");
        card_present = 1;
        wr(A_CLK, 2'b01, 32'h0008, "R5 clock off");
        wr(A_CLK + 1, 2'b00, 32'hFF, "R5 lane0 untouched");

        // R10 seed: half at offset 1 is a plain deposit
        host_dma_mode = 2'b10;
        halt_pulse();
        wr(A_AERR + 1, 2'b01, 32'hFFFF, "R10 plain half off1");
        rd(A_AERR, 2'b10, "R10 readback");
        wr(A_AERR, 2'b00, 32'h3C, "R10 plain byte off0");
        wr(A_AERR + 2, 2'b01, 32'h0200, "R10 plain half off2");
        rd(A_AERR, 2'b10, "R10 readback2");

        // R6 / R7 / R8: special path
        stopped_m = stopped_m; // stopped set, but write carries no continue
        wr(A_AERR + 1, 2'b00, 32'h00, "R7 byte off1 keep");
        rd(A_AERR, 2'b10, "R7 readback");
        wr(A_AERR + 1, 2'b00, 32'h01, "R8 w1c");
        rd(A_AERR + 1, 2'b00, "R8 readback");
        wr(A_AERR, 2'b01, 32'hABCD, "R6 half off0 with continue");
        rd(A_AERR, 2'b10, "R6 readback");

        // R9: each missing condition
        wr(A_AERR + 1, 2'b00, 32'h02, "R9 not stopped");
        halt_pulse();
        host_dma_mode = 2'b01;
        wr(A_AERR + 1, 2'b00, 32'h02, "R9 wrong mode");
        host_dma_mode = 2'b10;
        wr(A_AERR + 1, 2'b00, 32'h04, "R9 no continue");
        wr(A_AERR + 3, 2'b00, 32'h02, "R9 plain path");
        wr(A_AERR, 2'b10, 32'h0000_0200, "R9 word resume");

        // R12: halt coincides with a resuming write
        halt_pulse();
        adma_halt = 1;
        wr(A_AERR + 1, 2'b00, 32'h02, "R12 halt and resume");
        adma_halt = 0;
        wr(A_AERR + 1, 2'b00, 32'h02, "R12 still stopped");
        rd(A_AERR, 2'b10, "R12 final readback");

        repeat (2) cycle();
        done = 1;
        summary();
        $finish;
    end
endmodule